// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host on an 8-bit I/O bus access to a 256-entry byte-wide configuration array through two adjacent I/O addresses. The lower address holds an index register: writing it selects an array entry, reading it returns the current selection. The upper address is the data window: reads return the selected entry, writes update it, but only for entries the fixed write-protect map marks as writable. Writes to protected entries are dropped without trace.

A few entries come out of reset with fixed non-zero values that describe the default placement of on-board peripherals. Writing a different value into the two peripheral-placement entries (0xE7 and 0xE8) only changes the stored byte; nothing is relocated. The whole decoder answers only while an external enable input, driven from a bit in a separate configuration space, is high. When it is low, both addresses are released: reads are not claimed and writes have no effect.

Read responses are registered: the claim flag and the read byte appear one clock after the read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: A write to address BASE_ADDR (0x3F0) while enabled loads the index register with the written byte, and a read of BASE_ADDR returns the current index.
- R2: A read of address BASE_ADDR+1 (0x3F1) while enabled returns the array entry selected by the index, with io_claim high and the byte on io_rdata in the cycle after io_rd.
- R3: A data write while enabled stores the byte when the index is one of 0xE0-0xE3, 0xE6-0xE8, 0xEE-0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R4: A data write to any other index (0x00-0xDF, 0xE4, 0xE5, 0xE9-0xED, 0xF3, 0xF5, 0xF7, 0xF9-0xFB, 0xFD-0xFF) is discarded and the entry keeps its value.
- R5: After reset entry 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE; every other entry and the index register are 0x00.
- R6: While the enable input is low, reads of either address leave io_claim low and io_rdata at 0x00.
- R7: While the enable input is low, writes to either address change neither the index nor any entry.
- R8: Entries 0xE7 and 0xE8 store any written byte, including values other than their reset values.
- R9: Reads of addresses other than the two port addresses are never claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Decoder enable from the separate configuration space |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write byte |
| io_claim | output | 1 | Read claimed, one cycle after io_rd |
| io_rdata | output | 8 | Read byte, valid with io_claim |

## Verification
The hardest situation to reach from the ports is a write aimed at a protected entry that actually had the chance to land: it needs the index steered to each of the scattered read-only slots in the upper range and then a data write whose value differs from the stored one. The bench sweeps every index, writes a value derived from the index that never equals the reset value, and reads it back, then repeats with inverted data so both bit polarities are tried. Disabled-port writes are followed by enabled read-back so that a leaked write would show at the ports.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IDX_W   = 8;
  localparam int DATA_W  = 8;
  localparam int ENTRIES = 1 << IDX_W;

  // Write-protect map: only these indices accept data writes.
  function automatic logic cfg_writable(input logic [IDX_W-1:0] idx);
    return idx inside {[8'hE0:8'hE3], [8'hE6:8'hE8], [8'hEE:8'hF2],
                       8'hF4, 8'hF6, 8'hF8, 8'hFC};
  endfunction

  // Per-entry reset value.
  function automatic logic [DATA_W-1:0] cfg_reset_val(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              port_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              idx_hit,
  output logic              dat_hit
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  assign idx_hit = port_en && (addr == BASE_ADDR);
  assign dat_hit = port_en && (addr == DATA_ADDR);
endmodule

// File: rtl/sio_index_reg.sv
module sio_index_reg
  import sio_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] din,
  output logic [IDX_W-1:0] idx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    idx_q <= '0;
    else if (load) idx_q <= din;
  end
endmodule

// File: rtl/sio_cfg_array.sv
module sio_cfg_array
  import sio_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [IDX_W-1:0]  sel_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ent [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    localparam logic [IDX_W-1:0]  MY_IDX = IDX_W'(g);
    localparam logic [DATA_W-1:0] RST_V  = cfg_reset_val(MY_IDX);
    localparam bit                CAN_WR = cfg_writable(MY_IDX);
    if (CAN_WR) begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= RST_V;
        else if (wr_req && sel_idx == MY_IDX) q <= wdata;
      end
      assign ent[g] = q;
    end else begin : g_ro
      assign ent[g] = RST_V;
    end
  end

  assign rdata = ent[sel_idx];
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic              io_claim,
  output logic [DATA_W-1:0] io_rdata
);
  // Named internal events
  logic              idx_hit, dat_hit;
  logic              idx_wr_ev, dat_wr_ev, rd_ev;
  logic [IDX_W-1:0]  index_q;
  logic [DATA_W-1:0] sel_entry;

  sio_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .port_en (port_en),
    .addr    (io_addr),
    .idx_hit (idx_hit),
    .dat_hit (dat_hit)
  );

  assign idx_wr_ev = io_wr && idx_hit;
  assign dat_wr_ev = io_wr && dat_hit;
  assign rd_ev     = io_rd && (idx_hit || dat_hit);

  sio_index_reg u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (idx_wr_ev),
    .din   (io_wdata[IDX_W-1:0]),
    .idx_q (index_q)
  );

  sio_cfg_array u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (dat_wr_ev),
    .sel_idx (index_q),
    .wdata   (io_wdata),
    .rdata   (sel_entry)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_claim <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_claim <= rd_ev;
      if (rd_ev && idx_hit)      io_rdata <= DATA_W'(index_q);
      else if (rd_ev)            io_rdata <= sel_entry;
      else                       io_rdata <= '0;
    end
  end

  // R1: index write lands in the index register
  p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && io_wr && io_addr == BASE_ADDR) |=> index_q == $past(io_wdata[IDX_W-1:0]));

  // R2: data read returns the entry selected at the time of the read
  p_data_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && io_rd && io_addr == BASE_ADDR + ADDR_W'(1))
      |=> io_claim && io_rdata == $past(sel_entry));

  // R4: write to a protected entry leaves it unchanged
  p_ro_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr_ev && !cfg_writable(index_q)) |=> $stable(sel_entry));

  // R6: disabled port never claims
  p_off_noclaim_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !io_claim);

  // R7: disabled writes touch nothing visible
  p_off_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && io_wr) |=> $stable(index_q) && $stable(sel_entry));
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        io_claim;
  logic [7:0]  io_rdata;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_claim(io_claim), .io_rdata(io_rdata)
  );

  localparam logic [15:0] IDX_A = 16'h03F0;
  localparam logic [15:0] DAT_A = 16'h03F1;
  // Writable bits for indices 0xE0..0xFF, bit n = index 0xE0+n
  localparam logic [31:0] WMASK = 32'h1157C1CF;

  function automatic bit exp_wr(input int i);
    return (i >= 8'hE0) ? WMASK[i - 8'hE0] : 1'b0;
  endfunction

  function automatic logic [7:0] exp_rst(input int i);
    logic [7:0] v;
    v = 8'h00;
    if (i == 8'hE0) v = 8'h3C;
    if (i == 8'hE2) v = 8'h03;
    if (i == 8'hE3) v = 8'hFC;
    if (i == 8'hE6) v = 8'hDE;
    if (i == 8'hE7) v = 8'hFE;
    if (i == 8'hE8) v = 8'hBE;
    return v;
  endfunction

  function automatic logic [7:0] pat(input int i, input bit inv);
    logic [7:0] p;
    p = 8'((i * 37 + 11) ^ 8'h5A);
    if (p == exp_rst(i)) p = p ^ 8'h01;
    return inv ? ~p : p;
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a, output logic c, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    c = io_claim; d = io_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic c;
    logic [7:0] d;
    do_reset();
    check("R6 reset claim", {io_claim, io_rdata}, 9'h000);
    port_en = 1'b1;

    // R5: index and every entry after reset
    do_rd(IDX_A, c, d);
    check("R5 index reset", {c, d}, 9'h100);
    for (int i = 0; i < 256; i++) begin
      do_wr(IDX_A, 8'(i));
      do_rd(DAT_A, c, d);
      check("R5 entry reset", {c, d}, {1'b1, exp_rst(i)});
    end

    // R1: index readback
    for (int i = 0; i < 256; i += 17) begin
      do_wr(IDX_A, 8'(i));
      do_rd(IDX_A, c, d);
      check("R1 index readback", {c, d}, {1'b1, 8'(i)});
    end

    // R3/R4/R2: two full write/read sweeps with opposite data
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        do_wr(IDX_A, 8'(i));
        do_wr(DAT_A, pat(i, pass[0]));
      end
      for (int i = 255; i >= 0; i--) begin
        do_wr(IDX_A, 8'(i));
        do_rd(DAT_A, c, d);
        if (exp_wr(i)) check("R3 R2 writable stores", {c, d}, {1'b1, pat(i, pass[0])});
        else           check("R4 read-only kept", {c, d}, {1'b1, exp_rst(i)});
      end
    end

    // R8: placement entries take non-default values
    do_wr(IDX_A, 8'hE7); do_wr(DAT_A, 8'h12);
    do_rd(DAT_A, c, d);
    check("R8 entry E7", {c, d}, 9'h112);
    do_wr(IDX_A, 8'hE8); do_wr(DAT_A, 8'h00);
    do_rd(DAT_A, c, d);
    check("R8 entry E8", {c, d}, 9'h100);

    // R6/R7: disabled port
    do_wr(IDX_A, 8'hE0); do_wr(DAT_A, 8'h77);
    port_en = 1'b0;
    do_rd(IDX_A, c, d);
    check("R6 off index read", {c, d}, 9'h000);
    do_rd(DAT_A, c, d);
    check("R6 off data read", {c, d}, 9'h000);
    do_wr(DAT_A, 8'h99);
    do_wr(IDX_A, 8'hF0);
    port_en = 1'b1;
    do_rd(IDX_A, c, d);
    check("R7 off index write", {c, d}, 9'h1E0);
    do_rd(DAT_A, c, d);
    check("R7 off data write", {c, d}, 9'h177);

    // R9: neighbouring addresses
    do_rd(16'h03F2, c, d);
    check("R9 addr 3F2", {c, d}, 9'h000);
    do_rd(16'h02F1, c, d);
    check("R9 addr 2F1", {c, d}, 9'h000);
    do_rd(16'h03EF, c, d);
    check("R9 addr 3EF", {c, d}, 9'h000);

    // R5: reset restores defaults after writes
    do_reset();
    do_rd(IDX_A, c, d);
    check("R5 index after re-reset", {c, d}, 9'h100);
    do_wr(IDX_A, 8'hE0);
    do_rd(DAT_A, c, d);
    check("R5 E0 after re-reset", {c, d}, 9'h13C);
    do_wr(IDX_A, 8'hE7);
    do_rd(DAT_A, c, d);
    check("R5 E7 after re-reset", {c, d}, 9'h1FE);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule